// File: doc/BRIEF.md
# SDRAM Command Sequencer for Double-Data-Rate Memory

This block takes one abstract memory request at a time from an upstream sequencer and turns it into the SDRAM control-pin activity that carries it out. It drives the chip-select, row-strobe, column-strobe and write-enable lines, as well as the clock-enable line. It also drives the bank lines and the address lines. A row-select flag marks the cycle where the row address is presented. It waits out the delays the memory needs between commands. Read and write enables tell the external data path when a burst is in flight.

Refresh, precharge-all and mode-register loads take one command cycle each. A read or write is expanded into a fixed series of steps. The series starts with a row activation, followed by the row-to-column wait. The column command is then issued with auto-precharge requested. The data burst follows, and then the closing waits. A done pulse marks the end of every read and every write. The present state is visible on an output so the sequencer can track progress. The clock pair, the pad-level data and strobe logic, and the refresh interval timer all sit outside this block.

Top module: `sdram_cmd_engine`

## Requirements
- R1: While rst_n is low the state output is 0 (idle). The pins {cs_n,ras_n,cas_n,we_n} read 0111 (NOP), cke is low, and rd_en, wr_en, rd_done and wr_done are low. From the first clock edge after reset is released, cke is high and stays high.
- R2: The request code on req_op is 0 for none, 1 for refresh, 2 for precharge-all, 3 for mode load, 4 for read and 5 for write. Codes 6 and 7 are ignored. A request is taken only while the state is idle, and any req_op value in other states has no effect on the sequence.
- R3: Refresh drives pins 0001 for one cycle. Precharge-all drives 0010 with a[10]=1 for one cycle. Mode load drives 0000 for one cycle, with a equal to req_addr[11:0] and ba equal to req_addr[22:21]. Each is followed directly by idle.
- R4: The first cycle of a read or write is ACTIVE (pins 0011), with row_sel high. In that cycle a carries the row field req_addr[20:9] and ba carries the bank field req_addr[22:21].
- R5: A read runs in this order: ACTIVE, then two NOP cycles, then READ (0101). The READ cycle carries a[10]=1, a[11]=0, a[9]=0 and a[8:0]=req_addr[8:0]. CAS_LAT (default 2) NOP cycles follow. rd_en is then high for the burst length. After that, one cycle has rd_done high, and then the state is idle.
- R6: A write runs in this order: ACTIVE, then one NOP, then WRITE (0100) with the same column and auto-precharge address as R5. wr_en is then high for the burst length. Two NOP cycles follow (write recovery, then precharge period). wr_done is high for exactly the first idle cycle after that.
- R7: req_burst selects the burst length: 0 gives 2 cycles, 1 gives 4, and 2 or 3 give 8. It is captured when the request is taken.
- R8: The state output encodes the states as follows. Idle is 0. Refresh is 1, precharge is 2 and mode load is 3. Activate is 4. The read path uses 5 and 6 (first and second row waits), 7 (read command), 8 (latency wait), 9 (read data) and 10 (read done). The write path uses 11 (row wait), 12 (write command), 13 (write data), 14 (write recovery) and 15 (precharge wait).
- R9: Address and burst inputs are captured when a request is taken. Later changes to req_addr or req_burst do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 3 | Request code (R2) |
| req_addr | input | 23 | Request address: bank, row, column |
| req_burst | input | 2 | Burst length select (R7) |
| cke | output | 1 | Clock enable to memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank lines |
| a | output | 12 | Memory address lines |
| row_sel | output | 1 | Row address being presented |
| rd_en | output | 1 | Read data capture enable |
| wr_en | output | 1 | Write data drive enable |
| rd_done | output | 1 | Read complete pulse |
| wr_done | output | 1 | Write complete pulse |
| state | output | 4 | Present state code (R8) |

## Verification
The write-complete pulse is raised in the first idle cycle after a write. That is also the first cycle in which a new request can be taken, so the pulse and the acceptance of the next command fall in the same cycle. The vector table places a write straight before a read, and another write straight before a refresh. Each following request is presented in the very cycle that wr_done is high. The bench then judges two things: wr_done is seen in that idle cycle, and the next cycle already shows ACTIVE or refresh on the pins.

// File: rtl/sdram_cmd_engine.sv
module sdram_cmd_engine #(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int CAS_LAT = 2,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int CNT_W  = (CAS_LAT > 8) ? $clog2(CAS_LAT) + 1 : 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_burst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  a,
  output logic              row_sel,
  output logic              rd_en,
  output logic              wr_en,
  output logic              rd_done,
  output logic              wr_done,
  output logic [3:0]        state
);

  typedef enum logic [3:0] {
    S_IDLE = 4'd0,  S_REF  = 4'd1,  S_PRE  = 4'd2,  S_LMR  = 4'd3,
    S_ACT  = 4'd4,  S_RCR1 = 4'd5,  S_RCR2 = 4'd6,  S_RCMD = 4'd7,
    S_CAS  = 4'd8,  S_RDAT = 4'd9,  S_RDON = 4'd10, S_RCW  = 4'd11,
    S_WCMD = 4'd12, S_WDAT = 4'd13, S_TWR  = 4'd14, S_TRP  = 4'd15
  } st_t;

  st_t st, nx;
  logic [ADDR_W-1:0] lat_addr;
  logic [1:0]        lat_burst;
  logic              lat_wr;
  logic [CNT_W-1:0]  cnt, bl_last;
  logic              cke_q, wdone_q;
  logic [3:0]        pins;
  logic [ROW_W-1:0]  col_word;

  wire take = (st == S_IDLE) && (req_op >= 3'd1) && (req_op <= 3'd5);

  assign bl_last = (lat_burst == 2'd0) ? CNT_W'(1) :
                   (lat_burst == 2'd1) ? CNT_W'(3) : CNT_W'(7);

  always_comb begin
    nx = st;
    case (st)
      S_IDLE: case (req_op)
                3'd1:       nx = S_REF;
                3'd2:       nx = S_PRE;
                3'd3:       nx = S_LMR;
                3'd4, 3'd5: nx = S_ACT;
                default:    nx = S_IDLE;
              endcase
      S_REF, S_PRE, S_LMR: nx = S_IDLE;
      S_ACT:  nx = lat_wr ? S_RCW : S_RCR1;
      S_RCR1: nx = S_RCR2;
      S_RCR2: nx = S_RCMD;
      S_RCMD: nx = S_CAS;
      S_CAS:  if (cnt == CNT_W'(CAS_LAT - 1)) nx = S_RDAT;
      S_RDAT: if (cnt == bl_last) nx = S_RDON;
      S_RDON: nx = S_IDLE;
      S_RCW:  nx = S_WCMD;
      S_WCMD: nx = S_WDAT;
      S_WDAT: if (cnt == bl_last) nx = S_TWR;
      S_TWR:  nx = S_TRP;
      S_TRP:  nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      lat_addr  <= '0;
      lat_burst <= '0;
      lat_wr    <= 1'b0;
      cke_q     <= 1'b0;
      wdone_q   <= 1'b0;
    end else begin
      st      <= nx;
      cnt     <= (nx != st) ? '0 : cnt + 1'b1;
      cke_q   <= 1'b1;
      wdone_q <= (st == S_TRP);
      if (take) begin
        lat_addr  <= req_addr;
        lat_burst <= req_burst;
        lat_wr    <= (req_op == 3'd5);
      end
    end
  end

  always_comb begin
    col_word = '0;
    col_word[COL_W-1:0] = lat_addr[COL_W-1:0];
    col_word[10] = 1'b1;
  end

  always_comb begin
    pins = 4'b0111;
    a    = '0;
    case (st)
      S_REF:  pins = 4'b0001;
      S_PRE:  begin pins = 4'b0010; a[10] = 1'b1; end
      S_LMR:  begin pins = 4'b0000; a = lat_addr[ROW_W-1:0]; end
      S_ACT:  begin pins = 4'b0011; a = lat_addr[COL_W +: ROW_W]; end
      S_RCMD: begin pins = 4'b0101; a = col_word; end
      S_WCMD: begin pins = 4'b0100; a = col_word; end
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins;
  assign ba      = lat_addr[COL_W + ROW_W +: BANK_W];
  assign cke     = cke_q;
  assign row_sel = (st == S_ACT);
  assign rd_en   = (st == S_RDAT);
  assign wr_en   = (st == S_WDAT);
  assign rd_done = (st == S_RDON);
  assign wr_done = wdone_q;
  assign state   = st;

endmodule

// File: rtl/sdram_cmd_engine_sva.sv
module sdram_cmd_engine_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [11:0] a,
  input logic        rd_en,
  input logic        wr_en,
  input logic        rd_done,
  input logic        wr_done,
  input logic [3:0]  state
);
  wire [3:0] pins = {cs_n, ras_n, cas_n, we_n};

  a_r1_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd1 || state == 4'd2 || state == 4'd3) |=> state == 4'd0);

  a_r5_read_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0101) |-> $past(pins, 3) == 4'b0011);

  a_r6_write_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0100) |-> $past(pins, 2) == 4'b0011);

  a_r5_autoprecharge: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0101 || pins == 4'b0100) |-> a[10]);

  a_r6_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  a_r6_wr_done_after_trp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_done) |-> (state == 4'd0 && $past(state) == 4'd15));

  a_r5_rd_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (state == 4'd0 && !rd_done));
endmodule

bind sdram_cmd_engine sdram_cmd_engine_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .a(a), .rd_en(rd_en), .wr_en(wr_en),
  .rd_done(rd_done), .wr_done(wr_done), .state(state)
);

// File: tb/sdram_cmd_engine_bench.sv
module sdram_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [22:0] req_addr = '0;
  logic [1:0]  req_burst = 2'd0;
  logic        cke, cs_n, ras_n, cas_n, we_n, row_sel, rd_en, wr_en, rd_done, wr_done;
  logic [1:0]  ba;
  logic [11:0] a;
  logic [3:0]  state;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_engine u_sdram_cmd_engine (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_burst(req_burst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a(a), .row_sel(row_sel),
    .rd_en(rd_en), .wr_en(wr_en), .rd_done(rd_done), .wr_done(wr_done),
    .state(state)
  );

  // {op, burst, addr}
  localparam logic [27:0] VEC [10] = '{
    {3'd4, 2'd0, 23'h5AB3C1}, {3'd4, 2'd1, 23'h12F0FF},
    {3'd5, 2'd0, 23'h7ABCDE}, {3'd4, 2'd2, 23'h0001A5},
    {3'd5, 2'd2, 23'h3C3C3C}, {3'd1, 2'd0, 23'h000000},
    {3'd2, 2'd0, 23'h2AAAAA}, {3'd3, 2'd0, 23'h200432},
    {3'd5, 2'd1, 23'h654321}, {3'd4, 2'd3, 23'h1FEDCB}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pins_of(input int s);
    case (s)
      1: return 4'b0001;
      2: return 4'b0010;
      3: return 4'b0000;
      4: return 4'b0011;
      7: return 4'b0101;
      12: return 4'b0100;
      default: return 4'b0111;
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [1:0] bc,
                        input logic [22:0] ad, input logic [2:0] busy_op);
    int seq[40];
    int n = 0;
    int bl = (bc == 2'd0) ? 2 : (bc == 2'd1) ? 4 : 8;
    string tg;
    logic [11:0] colw;
    colw = {1'b0, 1'b1, 1'b0, ad[8:0]};
    case (op)
      3'd1: begin seq[n++] = 1; tg = "R3 R8"; end
      3'd2: begin seq[n++] = 2; tg = "R3 R8"; end
      3'd3: begin seq[n++] = 3; tg = "R3 R8"; end
      3'd4: begin
        tg = "R5 R7 R8";
        seq[n++] = 4; seq[n++] = 5; seq[n++] = 6; seq[n++] = 7;
        for (int i = 0; i < 2; i++) seq[n++] = 8;
        for (int i = 0; i < bl; i++) seq[n++] = 9;
        seq[n++] = 10;
      end
      default: begin
        tg = "R6 R7 R8";
        seq[n++] = 4; seq[n++] = 11; seq[n++] = 12;
        for (int i = 0; i < bl; i++) seq[n++] = 13;
        seq[n++] = 14; seq[n++] = 15;
      end
    endcase
    req_op = op; req_addr = ad; req_burst = bc;
    @(negedge clk);
    req_op = busy_op; req_addr = ~ad; req_burst = ~bc;
    for (int i = 0; i < n; i++) begin
      logic [11:0] av, ev;
      av = {state, cs_n, ras_n, cas_n, we_n, rd_en, wr_en, rd_done, wr_done};
      ev = {4'(seq[i]), pins_of(seq[i]), seq[i] == 9, seq[i] == 13, seq[i] == 10, 1'b0};
      chk(av == ev, tg, "state/pins/flags", 32'(av), 32'(ev));
      case (seq[i])
        4:  chk({row_sel, ba, a} == {1'b1, ad[22:21], ad[20:9]}, "R4 R9",
                "activate row", 32'({row_sel, ba, a}), 32'({1'b1, ad[22:21], ad[20:9]}));
        7, 12: chk({ba, a} == {ad[22:21], colw}, (seq[i] == 7) ? "R5 R9" : "R6 R9",
                "column auto-precharge", 32'({ba, a}), 32'({ad[22:21], colw}));
        3:  chk({ba, a} == {ad[22:21], ad[11:0]}, "R3 R9", "mode load address",
                32'({ba, a}), 32'({ad[22:21], ad[11:0]}));
        2:  chk(a[10] == 1'b1, "R3", "precharge-all a10", 32'(a[10]), 32'd1);
        default: ;
      endcase
      @(negedge clk);
    end
    chk(state == 4'd0 && wr_done == (op == 3'd5) && rd_done == 1'b0 &&
        {cs_n, ras_n, cas_n, we_n} == 4'b0111,
        (op == 3'd5) ? "R6" : "R2", "return to idle / wr_done",
        32'({state, wr_done, cs_n, ras_n, cas_n, we_n}),
        32'({4'd0, op == 3'd5, 4'b0111}));
    req_op = 3'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cke, state, cs_n, ras_n, cas_n, we_n, rd_en, wr_en, rd_done, wr_done} ==
        {1'b0, 4'd0, 4'b0111, 4'b0000}, "R1", "in reset",
        32'({cke, state, cs_n, ras_n, cas_n, we_n, rd_en, wr_en, rd_done, wr_done}),
        32'({1'b0, 4'd0, 4'b0111, 4'b0000}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(cke == 1'b1 && state == 4'd0, "R1", "cke after reset", 32'({cke, state}), 32'h10);

    for (int v = 0; v < 10; v++)
      run_op(VEC[v][27:25], VEC[v][24:23], VEC[v][22:0], 3'd0);

    // R2: reserved codes in idle are ignored
    for (int c = 6; c < 8; c++) begin
      req_op = 3'(c); req_addr = 23'h7FFFFF;
      @(negedge clk);
      chk(state == 4'd0 && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2",
          "reserved code ignored", 32'({state, cs_n, ras_n, cas_n, we_n}), 32'h07);
    end
    req_op = 3'd0;
    @(negedge clk);

    // R2: requests held during a busy read or write are ignored
    run_op(3'd4, 2'd1, 23'h0ABCDE, 3'd1);
    run_op(3'd5, 2'd0, 23'h555555, 3'd3);
    // back-to-back: refresh taken in the wr_done cycle
    run_op(3'd1, 2'd0, 23'h000000, 3'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule